// File: doc/BRIEF.md
# Clear-on-read interrupt flag register

This block collects event indications from a small bus controller core into an 8-bit flag register. It has five sources. Two are receive and transmit pulses. One is an error source that reacts when either of two status levels changes. One is an overrun source that reacts only when its status level goes from low to high. The last is a wake-up pulse. Each source has its own enable, and a flag sets only when the event occurs while that enable is high. The change and edge detection compares each status level with a copy registered on the previous clock.

The host reads the register through `flags_o`, and it asserts `rd_i` for the cycle of the read access. That read clears every flag at the next clock edge. A flag whose source fires in the same cycle as the read stays set, so no event is lost. `irq_o` is high while any flag is set.

The registered status copies reset to zero. A status input that is high when reset is released therefore counts as a change on the first clock.

Top module: `irq_flag_reg`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it rises with all inputs low, `flags_o` is 8'h00 and `irq_o` is 0.
- R2: Bit 0 of `flags_o` sets at the clock edge where `rx_evt_i` and `rx_en_i` are both high.
- R3: Bit 1 of `flags_o` sets at the clock edge where `tx_evt_i` and `tx_en_i` are both high.
- R4: Bit 2 of `flags_o` sets at the clock edge where `err_en_i` is high and either `err_stat_i` or `bus_stat_i` differs from its value at the previous edge. Both rising and falling changes count.
- R5: Bit 3 of `flags_o` sets at the clock edge where `ovr_en_i` is high and `ovr_stat_i` has risen from 0 to 1 since the previous edge. A falling `ovr_stat_i` sets nothing.
- R6: Bit 4 of `flags_o` sets at the clock edge where `wake_evt_i` and `wake_en_i` are both high.
- R7: An event that arrives while its enable is low sets nothing. This holds even if the enable goes high afterwards.
- R8: Bits 7 to 5 of `flags_o` always read 0.
- R9: A cycle with `rd_i` high clears all flags at the next edge, except flags whose source fires in that same cycle.
- R10: A flag whose enabled source fires in the same cycle as `rd_i` is set after that edge.
- R11: `irq_o` is 1 exactly when at least one bit of `flags_o` is 1.
- R12: Without `rd_i`, a set flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_evt_i | input | 1 | Receive event pulse |
| tx_evt_i | input | 1 | Transmit event pulse |
| err_stat_i | input | 1 | Error status level |
| bus_stat_i | input | 1 | Bus status level |
| ovr_stat_i | input | 1 | Data overrun status level |
| wake_evt_i | input | 1 | Wake-up (sleep exit) pulse |
| rx_en_i | input | 1 | Receive flag enable |
| tx_en_i | input | 1 | Transmit flag enable |
| err_en_i | input | 1 | Error flag enable |
| ovr_en_i | input | 1 | Overrun flag enable |
| wake_en_i | input | 1 | Wake-up flag enable |
| rd_i | input | 1 | Host read strobe; clears the flags |
| flags_o | output | 8 | Flag register read value |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle the rules that can be stated one edge at a time:
- the reserved bits read zero;
- flags hold without a read;
- enabled pulses, status changes and overrun rising edges set their bit, even when a read arrives in the same cycle;
- a read with every source quiet leaves the register empty.

The bench scenarios show the rest:
- the full sweep of all 32 enable combinations against every source;
- a falling overrun level sets nothing;
- a change seen while an enable is low stays lost after the enable is raised;
- the exact mix of cleared and kept bits when a read and an event arrive together.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int unsigned REG_W = 8;
  localparam int unsigned SRC_N = 5;

  localparam int unsigned BIT_RX   = 0;
  localparam int unsigned BIT_TX   = 1;
  localparam int unsigned BIT_ERR  = 2;
  localparam int unsigned BIT_OVR  = 3;
  localparam int unsigned BIT_WAKE = 4;

  typedef enum logic [0:0] {
    DET_ANY  = 1'b0,
    DET_RISE = 1'b1
  } det_mode_e;
endpackage

// File: rtl/irq_change_det.sv
module irq_change_det
  import irq_flag_pkg::*;
#(
  parameter int unsigned W    = 1,
  parameter det_mode_e   MODE = DET_ANY
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic         hit_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] hit_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sig_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MODE == DET_RISE) begin : g_rise
      assign hit_b[i] = sig_i[i] & ~prev_q[i];
    end else begin : g_any
      assign hit_b[i] = sig_i[i] ^ prev_q[i];
    end
  end

  assign hit_o = |hit_b;
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic flag_q;
    // set has priority over the read clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q <= 1'b0;
      else if (set_i[i]) flag_q <= 1'b1;
      else if (clr_i)    flag_q <= 1'b0;
    end
    assign flag_o[i] = flag_q;
  end
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
  import irq_flag_pkg::*;
#(
  parameter int unsigned FLAG_W = REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_evt_i,
  input  logic              tx_evt_i,
  input  logic              err_stat_i,
  input  logic              bus_stat_i,
  input  logic              ovr_stat_i,
  input  logic              wake_evt_i,
  input  logic              rx_en_i,
  input  logic              tx_en_i,
  input  logic              err_en_i,
  input  logic              ovr_en_i,
  input  logic              wake_en_i,
  input  logic              rd_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              irq_o
);
  localparam int unsigned PAD_W = FLAG_W - SRC_N;

  logic             err_hit;
  logic             ovr_hit;
  logic [SRC_N-1:0] set_vec;
  logic [SRC_N-1:0] flag_vec;

  irq_change_det #(.W(2), .MODE(DET_ANY)) u_err_det (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i ({bus_stat_i, err_stat_i}),
    .hit_o (err_hit)
  );

  irq_change_det #(.W(1), .MODE(DET_RISE)) u_ovr_det (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (ovr_stat_i),
    .hit_o (ovr_hit)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[BIT_RX]   = rx_evt_i   & rx_en_i;
    set_vec[BIT_TX]   = tx_evt_i   & tx_en_i;
    set_vec[BIT_ERR]  = err_hit    & err_en_i;
    set_vec[BIT_OVR]  = ovr_hit    & ovr_en_i;
    set_vec[BIT_WAKE] = wake_evt_i & wake_en_i;
  end

  irq_flag_bank #(.N(SRC_N)) u_bank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_vec),
    .clr_i (rd_i),
    .flag_o(flag_vec)
  );

  assign flags_o = {{PAD_W{1'b0}}, flag_vec};
  assign irq_o   = |flag_vec;
endmodule

// File: rtl/irq_flag_reg_chk.sv
module irq_flag_reg_chk
  import irq_flag_pkg::*;
#(
  parameter int unsigned FLAG_W = REG_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_evt_i,
  input logic              tx_evt_i,
  input logic              err_stat_i,
  input logic              bus_stat_i,
  input logic              ovr_stat_i,
  input logic              wake_evt_i,
  input logic              rx_en_i,
  input logic              tx_en_i,
  input logic              err_en_i,
  input logic              ovr_en_i,
  input logic              wake_en_i,
  input logic              rd_i,
  input logic [FLAG_W-1:0] flags_o,
  input logic              irq_o
);
  a_r8_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[FLAG_W-1:SRC_N] == '0);

  a_r12_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

  a_r2_rx_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_evt_i && rx_en_i |=> flags_o[BIT_RX]);

  a_r3_tx_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_evt_i && tx_en_i |=> flags_o[BIT_TX]);

  a_r4_err_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_en_i && (!$stable(err_stat_i) || !$stable(bus_stat_i)) |=> flags_o[BIT_ERR]);

  a_r5_ovr_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_en_i && $rose(ovr_stat_i) |=> flags_o[BIT_OVR]);

  a_r6_wake_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_evt_i && wake_en_i |=> flags_o[BIT_WAKE]);

  // R9, R11: a read with every source quiet or disabled leaves nothing pending
  a_r9_read_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !(rx_evt_i && rx_en_i) && !(tx_evt_i && tx_en_i) && !err_en_i
      && !ovr_en_i && !(wake_evt_i && wake_en_i) |=> (flags_o == '0) && !irq_o);
endmodule

bind irq_flag_reg irq_flag_reg_chk #(.FLAG_W(FLAG_W)) u_chk (.*);

// File: tb/irq_flag_reg_test.sv
`timescale 1ns/1ps
module irq_flag_reg_test;
  logic clk_i = 1'b0;
  always #2.5 clk_i = ~clk_i;

  logic rst_ni;
  logic rx_evt_i, tx_evt_i, err_stat_i, bus_stat_i, ovr_stat_i, wake_evt_i;
  logic [4:0] en_v;
  logic rd_i;
  logic [7:0] flags_o;
  logic irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  irq_flag_reg uut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rx_evt_i(rx_evt_i), .tx_evt_i(tx_evt_i),
    .err_stat_i(err_stat_i), .bus_stat_i(bus_stat_i),
    .ovr_stat_i(ovr_stat_i), .wake_evt_i(wake_evt_i),
    .rx_en_i(en_v[0]), .tx_en_i(en_v[1]), .err_en_i(en_v[2]),
    .ovr_en_i(en_v[3]), .wake_en_i(en_v[4]),
    .rd_i(rd_i), .flags_o(flags_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // flags, irq (R11) and reserved bits (R8) together
  task automatic chk_all(input string req, input logic [7:0] exp);
    chk(req, flags_o, exp);
    chk("R11", {7'b0, irq_o}, {7'b0, exp != 8'h00});
    chk("R8", {5'b0, flags_o[7:5]}, 8'h00);
  endtask

  task automatic do_read();
    rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0;
    {rx_evt_i, tx_evt_i, err_stat_i, bus_stat_i, ovr_stat_i, wake_evt_i} = '0;
    en_v = '0;
    rd_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk_all("R1", 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_all("R1", 8'h00);

    // sweep every enable pattern against every source
    for (int e = 0; e < 32; e++) begin
      en_v = e[4:0];
      for (int s = 0; s < 7; s++) begin
        logic [7:0] exp;
        string tag;
        exp = 8'h00;
        case (s)
          0: begin rx_evt_i = 1'b1; exp[0] = en_v[0]; tag = "R2"; end
          1: begin tx_evt_i = 1'b1; exp[1] = en_v[1]; tag = "R3"; end
          2: begin err_stat_i = ~err_stat_i; exp[2] = en_v[2]; tag = "R4"; end
          3: begin bus_stat_i = ~bus_stat_i; exp[2] = en_v[2]; tag = "R4"; end
          4: begin ovr_stat_i = 1'b1; exp[3] = en_v[3]; tag = "R5"; end
          5: begin ovr_stat_i = 1'b0; tag = "R5"; end
          default: begin wake_evt_i = 1'b1; exp[4] = en_v[4]; tag = "R6"; end
        endcase
        @(negedge clk_i);
        rx_evt_i = 1'b0; tx_evt_i = 1'b0; wake_evt_i = 1'b0;
        if (exp == 8'h00) chk_all({tag, "/R7"}, exp);
        else              chk_all(tag, exp);
        @(negedge clk_i);
        chk_all("R12", exp);
        do_read();
        chk_all("R9", 8'h00);
      end
    end

    // R7: a change seen while disabled is not replayed on enable
    en_v = 5'b00000;
    err_stat_i = ~err_stat_i;
    @(negedge clk_i);
    en_v = 5'b00100;
    @(negedge clk_i);
    chk_all("R7", 8'h00);
    en_v = 5'b00000;
    ovr_stat_i = 1'b1;
    @(negedge clk_i);
    en_v = 5'b01000;
    @(negedge clk_i);
    chk_all("R7", 8'h00);
    en_v = 5'b11111;
    ovr_stat_i = 1'b0;
    @(negedge clk_i);
    chk_all("R5", 8'h00);

    // R10: event in the read cycle survives, older flag clears
    rx_evt_i = 1'b1;
    @(negedge clk_i);
    rx_evt_i = 1'b0;
    chk_all("R2", 8'h01);
    tx_evt_i = 1'b1;
    rd_i = 1'b1;
    @(negedge clk_i);
    tx_evt_i = 1'b0;
    rd_i = 1'b0;
    chk_all("R10", 8'h02);
    err_stat_i = ~err_stat_i;
    rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
    chk_all("R10", 8'h04);
    do_read();
    chk_all("R9", 8'h00);

    finish_run();
  end
endmodule